// File: doc/BRIEF.md
# Spectral Peak Detector

This block watches a stream of unsigned 32-bit spectral magnitudes, one bin per accepted sample, and picks out the local maxima that rise above their left neighbour by more than a programmable margin. A frame of bins opens with a start marker and closes with a last marker. Each accepted peak is reported once, with its magnitude and its bin position counted from the start of the frame. When a frame closes, the block raises a one-cycle end pulse together with the number of peaks found in that frame.

Internally, a three-stage sliding window holds the newest, middle and oldest samples of the current frame. A slope test checks that the middle sample is strictly larger than both of its neighbours. A margin test subtracts the older neighbour from the middle sample and requires the difference to exceed the threshold. The threshold is captured when the frame opens. Samples arriving while valid is low, before any frame start, or after a frame's last marker are ignored.

Top module: `pkd_top`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `peak_o` and `eof_o` are 0 and `count_o` is 0.
- R2: The bin at index i is reported as a peak when its sample is strictly greater than both the sample at i-1 and the sample at i+1. The report comes in the cycle after the clock edge that accepts sample i+1: `peak_o`=1, `peak_val_o` is the sample at i and `peak_idx_o`=i.
- R3: A peak also requires (sample[i] - sample[i-1]) > threshold, with both sides treated as unsigned 32-bit numbers. A margin equal to the threshold is rejected.
- R4: When two adjacent samples are equal, neither of them is reported, so a flat top gives no peak.
- R5: Bin 0 and the last bin of a frame are never reported.
- R6: The threshold used for a whole frame is the value of `thr_i` in the cycle where the frame-start sample is accepted. Later changes to `thr_i` have no effect on that frame.
- R7: `eof_o` pulses for exactly one cycle, in the cycle after the edge that accepts the sample marked last. In that cycle `count_o` equals the number of peaks in the frame, including a peak reported in the same cycle.
- R8: The peak count saturates at 2^CNT_W-1 and does not wrap.
- R9: A sample is ignored when `in_valid` is low, or when it arrives outside a frame (before the first start marker, or after a last marker without a new start marker). Ignored samples cause no peaks, no end pulse and no index advance.
- R10: The bin index restarts at 0 with every accepted start marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears the window and all state |
| in_valid | input | 1 | Qualifies the sample on `in_data` |
| in_sof | input | 1 | Marks the first bin of a frame |
| in_last | input | 1 | Marks the last bin of a frame |
| in_data | input | DW | Unsigned spectral magnitude |
| thr_i | input | DW | Margin threshold, captured at frame start |
| peak_o | output | 1 | One-cycle flag for an accepted peak |
| peak_val_o | output | DW | Magnitude of the reported peak |
| peak_idx_o | output | IW | Bin index of the reported peak |
| eof_o | output | 1 | One-cycle end-of-frame pulse |
| count_o | output | CNT_W | Peaks in the frame, valid while `eof_o` is high |

## Verification
The bench builds the block with CNT_W=3 and IW=8. The 3-bit count makes saturation reachable: a 20-bin frame with alternating high and low values holds nine peaks but must report seven. The 8-bit index is ample for frames of up to 40 bins. Random frames draw magnitudes from a narrow range so that plateaus and equal neighbours occur often, and they mix in idle gaps, stray markers and traffic outside any frame. Directed frames cover a margin exactly equal to the threshold, a large unsigned step and a single-bin frame.

// File: rtl/pkd_pkg.sv
package pkd_pkg;

    localparam int WIN_DEPTH = 3;

    typedef enum logic [1:0] {
        FILL_NONE = 2'd0,
        FILL_ONE  = 2'd1,
        FILL_TWO  = 2'd2,
        FILL_FULL = 2'd3
    } fill_e;

    function automatic fill_e fill_step(input fill_e f);
        if (f == FILL_FULL) return FILL_FULL;
        return fill_e'(f + 2'd1);
    endfunction

endpackage

// File: rtl/pkd_window.sv
module pkd_window
    import pkd_pkg::*;
#(
    parameter int DW = 32,
    parameter int IW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic          in_sof,
    input  logic          in_last,
    input  logic [DW-1:0] in_data,
    input  logic [DW-1:0] thr_i,
    output logic          fresh_o,
    output logic          last_o,
    output logic          full_o,
    output logic [DW-1:0] left_o,
    output logic [DW-1:0] mid_o,
    output logic [DW-1:0] right_o,
    output logic [DW-1:0] thr_o,
    output logic [IW-1:0] mid_idx_o,
    output logic          clr_o
);

    typedef struct packed {
        logic [WIN_DEPTH-1:0][DW-1:0] win;
        fill_e                        fill;
        logic [IW-1:0]                idx;
        logic [DW-1:0]                thr;
        logic                         in_frame;
        logic                         fresh;
        logic                         last;
    } win_st_t;

    win_st_t st_d, st_q;
    logic    accept;

    always_comb begin
        st_d       = st_q;
        st_d.fresh = 1'b0;
        st_d.last  = 1'b0;
        accept     = in_valid && (in_sof || st_q.in_frame);
        if (accept) begin
            st_d.win[0] = in_data;
            for (int k = 1; k < WIN_DEPTH; k++) begin
                st_d.win[k] = st_q.win[k-1];
            end
            st_d.fresh    = 1'b1;
            st_d.last     = in_last;
            st_d.in_frame = !in_last;
            if (in_sof) begin
                st_d.fill = FILL_ONE;
                st_d.idx  = IW'(1);
                st_d.thr  = thr_i;
            end else begin
                st_d.fill = fill_step(st_q.fill);
                st_d.idx  = st_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fresh_o   = st_q.fresh;
    assign last_o    = st_q.last;
    assign full_o    = (st_q.fill == FILL_FULL);
    assign right_o   = st_q.win[0];
    assign mid_o     = st_q.win[1];
    assign left_o    = st_q.win[2];
    assign thr_o     = st_q.thr;
    assign mid_idx_o = st_q.idx - IW'(2);
    assign clr_o     = in_valid && in_sof;

endmodule

// File: rtl/pkd_judge.sv
module pkd_judge #(
    parameter int DW = 32
) (
    input  logic          fresh_i,
    input  logic          full_i,
    input  logic [DW-1:0] left_i,
    input  logic [DW-1:0] mid_i,
    input  logic [DW-1:0] right_i,
    input  logic [DW-1:0] thr_i,
    output logic          hit_o
);

    logic          rising;
    logic          falling;
    logic [DW-1:0] margin;
    logic          clears;

    always_comb begin
        rising  = mid_i > left_i;
        falling = mid_i > right_i;
        margin  = mid_i - left_i;
        clears  = margin > thr_i;
        hit_o   = fresh_i && full_i && rising && falling && clears;
    end

endmodule

// File: rtl/pkd_tally.sv
module pkd_tally #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             hit_i,
    output logic [CNT_W-1:0] count_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tally_st_t;

    tally_st_t st_d, st_q;
    logic [CNT_W-1:0] sum;

    always_comb begin
        sum = st_q.cnt;
        if (hit_i && (st_q.cnt != CNT_MAX)) begin
            sum = st_q.cnt + CNT_W'(1);
        end
        st_d.cnt = clr_i ? '0 : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = sum;

endmodule

// File: rtl/pkd_top.sv
module pkd_top #(
    parameter int DW    = 32,
    parameter int IW    = 10,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_sof,
    input  logic             in_last,
    input  logic [DW-1:0]    in_data,
    input  logic [DW-1:0]    thr_i,
    output logic             peak_o,
    output logic [DW-1:0]    peak_val_o,
    output logic [IW-1:0]    peak_idx_o,
    output logic             eof_o,
    output logic [CNT_W-1:0] count_o
);

    logic          fresh;
    logic          last;
    logic          full;
    logic [DW-1:0] left_s;
    logic [DW-1:0] mid_s;
    logic [DW-1:0] right_s;
    logic [DW-1:0] thr_s;
    logic [IW-1:0] mid_idx;
    logic          clr;
    logic          hit;

    pkd_window #(.DW(DW), .IW(IW)) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_last   (in_last),
        .in_data   (in_data),
        .thr_i     (thr_i),
        .fresh_o   (fresh),
        .last_o    (last),
        .full_o    (full),
        .left_o    (left_s),
        .mid_o     (mid_s),
        .right_o   (right_s),
        .thr_o     (thr_s),
        .mid_idx_o (mid_idx),
        .clr_o     (clr)
    );

    pkd_judge #(.DW(DW)) u_judge (
        .fresh_i (fresh),
        .full_i  (full),
        .left_i  (left_s),
        .mid_i   (mid_s),
        .right_i (right_s),
        .thr_i   (thr_s),
        .hit_o   (hit)
    );

    pkd_tally #(.CNT_W(CNT_W)) u_tally (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .hit_i   (hit),
        .count_o (count_o)
    );

    assign peak_o     = hit;
    assign peak_val_o = mid_s;
    assign peak_idx_o = mid_idx;
    assign eof_o      = fresh && last;

endmodule

// File: rtl/pkd_chk.sv
module pkd_chk #(
    parameter int DW = 32,
    parameter int IW = 10
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_last,
    input logic [DW-1:0] in_data,
    input logic          peak_o,
    input logic [DW-1:0] peak_val_o,
    input logic [IW-1:0] peak_idx_o,
    input logic          eof_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!peak_o && !eof_o));

    // R5
    no_first_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |-> (peak_idx_o != '0));

    // R2
    right_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |-> (peak_val_o > $past(in_data)));

    // R9
    peak_after_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        peak_o |-> $past(in_valid));

    // R7
    eof_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |-> $past(in_valid && in_last));

    // R7
    eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);

endmodule

bind pkd_top pkd_chk #(.DW(DW), .IW(IW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_data    (in_data),
    .peak_o     (peak_o),
    .peak_val_o (peak_val_o),
    .peak_idx_o (peak_idx_o),
    .eof_o      (eof_o)
);

// File: tb/tb_pkd_top.sv
module tb_pkd_top;

    localparam int CLK_PERIOD = 10;
    localparam int DW    = 32;
    localparam int IW    = 8;
    localparam int CNT_W = 3;
    localparam int CMAX  = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             in_valid;
    logic             in_sof;
    logic             in_last;
    logic [DW-1:0]    in_data;
    logic [DW-1:0]    thr_i;
    logic             peak_o;
    logic [DW-1:0]    peak_val_o;
    logic [IW-1:0]    peak_idx_o;
    logic             eof_o;
    logic [CNT_W-1:0] count_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    logic [DW-1:0] frm [64];
    int unsigned   obs_idx[$];
    logic [DW-1:0] obs_val[$];
    int            eof_seen;
    int            eof_cnt;

    pkd_top #(.DW(DW), .IW(IW), .CNT_W(CNT_W)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_sof     (in_sof),
        .in_last    (in_last),
        .in_data    (in_data),
        .thr_i      (thr_i),
        .peak_o     (peak_o),
        .peak_val_o (peak_val_o),
        .peak_idx_o (peak_idx_o),
        .eof_o      (eof_o),
        .count_o    (count_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (peak_o) begin
                obs_idx.push_back(int'(peak_idx_o));
                obs_val.push_back(peak_val_o);
            end
            if (eof_o) begin
                eof_seen++;
                eof_cnt = int'(count_o);
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
            in_data = $urandom; thr_i = $urandom;
            @(negedge clk);
        end
    endtask

    // R9: valid samples that arrive outside any frame
    task automatic junk(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b1; in_sof = 1'b0; in_last = $urandom_range(0, 1);
            in_data = $urandom; thr_i = 0;
            @(negedge clk);
        end
        in_valid = 1'b0;
    endtask

    // R6: thr_i takes random values after the start sample
    task automatic send_frame(input int n, input logic [DW-1:0] thr, input bit gaps);
        for (int i = 0; i < n; i++) begin
            if (gaps) begin
                while ($urandom_range(0, 2) == 0) begin
                    in_valid = 1'b0; in_sof = $urandom_range(0, 1);
                    in_last = $urandom_range(0, 1); in_data = $urandom;
                    thr_i = $urandom;
                    @(negedge clk);
                end
            end
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_last  = (i == n - 1);
            in_data  = frm[i];
            thr_i    = (i == 0) ? thr : $urandom;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
    endtask

    task automatic check_frame(input int n, input logic [DW-1:0] thr, input string tag);
        int unsigned e_idx[$];
        logic [DW-1:0] e_val[$];
        int ecount;
        for (int i = 1; i + 1 < n; i++) begin
            if (frm[i] > frm[i-1] && frm[i] > frm[i+1] && (frm[i] - frm[i-1]) > thr) begin
                e_idx.push_back(i);
                e_val.push_back(frm[i]);
            end
        end
        ecount = (e_idx.size() > CMAX) ? CMAX : e_idx.size();
        chk(obs_idx.size() == e_idx.size(), {tag, " peak number"}, obs_idx.size(), e_idx.size());
        if (obs_idx.size() == e_idx.size()) begin
            for (int k = 0; k < e_idx.size(); k++) begin
                chk(obs_idx[k] == e_idx[k], {tag, " R10 peak index"}, obs_idx[k], e_idx[k]);
                chk(obs_val[k] == e_val[k], {tag, " R2 peak value"}, obs_val[k], e_val[k]);
            end
        end
        chk(eof_seen == 1, "R7 eof pulses", eof_seen, 1);
        chk(eof_cnt == ecount, (e_idx.size() > CMAX) ? "R8 saturated count" : "R7 count", eof_cnt, ecount);
        obs_idx.delete();
        obs_val.delete();
        eof_seen = 0;
        eof_cnt  = -1;
    endtask

    task automatic run(input int n, input logic [DW-1:0] thr, input bit gaps, input string tag);
        send_frame(n, thr, gaps);
        junk($urandom_range(0, 4));
        idle(3);
        check_frame(n, thr, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
        in_data = '0; thr_i = '0;
        eof_seen = 0; eof_cnt = -1;
        repeat (3) @(negedge clk);
        // R1
        chk(!peak_o && !eof_o, "R1 flags in reset", {peak_o, eof_o}, 0);
        chk(count_o == 0, "R1 count in reset", count_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!peak_o && !eof_o && count_o == 0, "R1 after release", {peak_o, eof_o}, 0);

        // R9: traffic before any start marker is dropped
        junk(6);
        idle(2);
        chk(obs_idx.size() == 0 && eof_seen == 0, "R9 pre-frame", obs_idx.size() + eof_seen, 0);

        // R2 simple peak
        frm[0] = 1; frm[1] = 5; frm[2] = 2;
        run(3, 3, 0, "R2");
        // R3 margin equal to threshold rejected, one below accepted
        frm[0] = 1; frm[1] = 4; frm[2] = 2;
        run(3, 3, 0, "R3 equal");
        run(3, 2, 1, "R3 below");
        // R3 large unsigned step
        frm[0] = 0; frm[1] = 32'hFFFF_FFF0; frm[2] = 0;
        run(3, 32'h7FFF_FFFF, 0, "R3 unsigned");
        // R4 plateaus
        frm[0] = 1; frm[1] = 5; frm[2] = 5; frm[3] = 2;
        run(4, 0, 0, "R4 pair");
        frm[0] = 2; frm[1] = 7; frm[2] = 7; frm[3] = 7; frm[4] = 3;
        run(5, 0, 1, "R4 flat");
        // R5 edge bins
        frm[0] = 9; frm[1] = 1; frm[2] = 2; frm[3] = 1; frm[4] = 8;
        run(5, 0, 0, "R5");
        // R7 single-bin frame
        frm[0] = 77;
        run(1, 0, 0, "R7 single");
        // R6 threshold held although thr_i changes later
        frm[0] = 0; frm[1] = 100; frm[2] = 0; frm[3] = 60; frm[4] = 0;
        run(5, 70, 0, "R6");
        // R8 saturation: nine peaks in twenty bins
        for (int i = 0; i < 20; i++) frm[i] = (i % 2 == 1) ? 10 : 0;
        run(20, 0, 1, "R8");

        // random frames, R10 indices restart every frame
        for (int f = 0; f < 40; f++) begin
            int n;
            n = $urandom_range(3, 40);
            for (int i = 0; i < n; i++) frm[i] = $urandom_range(0, 12);
            run(n, $urandom_range(0, 5), 1, "R2 random");
        end

        finish_run();
    end

endmodule